// File: doc/BRIEF.md
# Dual-Stream Recursive Boxcar Averager

This block smooths two independent 12-bit sample streams, for example a current reading and a voltage reading from a converter. Each stream has its own 32-deep boxcar window. The block does not add 32 values on every sample. Instead it keeps a running sum per stream. On each accepted sample, the value that drops out of the window is taken away from the incoming value, and that difference is folded into the sum. The average is the running sum shifted right by five bits, which truncates toward minus infinity.

Each stream advances only on a clock where its own strobe is high. Between strobes its history, sum and average stay frozen. A single build-time parameter selects two's-complement or plain binary sample interpretation, and the same setting applies to both streams. After 32 samples have been accepted since reset, each stream gives a one-cycle valid pulse following every accepted sample. The average is visible earlier, but during fill-up it ramps up from zero.

Top module: `dual_boxcar_avg`

## Requirements
- R1: While `rst_n` is low at a rising edge, both averages become 0 and both valid flags become 0. Every history entry and both sums are cleared.
- R2: With the signed mode (default), each sample is a 12-bit two's-complement value, so 0x800 means -2048. The average equals floor(sum of the last 32 accepted samples / 32), given as 12-bit two's complement.
- R3: The average reflects a sample accepted at rising edge k from just after edge k onward. At an edge where the stream's strobe is low, its average does not change.
- R4: The running sum never overflows, whatever the input. 32 samples of 0x7FF give 0x7FF and 32 samples of 0x800 give 0x800 in signed mode. 32 samples of 0xFFF give 0xFFF in unsigned mode.
- R5: Before 32 samples have been accepted, missing window slots count as zero. After k samples the output is floor(sum of those k samples / 32).
- R6: The valid flag is high for exactly the cycle after an accepted sample, and only once at least 32 samples have been accepted since reset. It is low in every cycle that follows an edge with no strobe.
- R7: The two streams keep separate histories and sums. Strobes and samples on one stream never alter the other stream's average or valid flag.
- R8: With the unsigned mode, each sample is a 12-bit plain binary value from 0 to 4095. The average is floor(sum of the last 32 accepted samples / 32), given as a 12-bit binary value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_stb | input | 1 | Stream A sample strobe |
| a_smp | input | 12 | Stream A sample |
| b_stb | input | 1 | Stream B sample strobe |
| b_smp | input | 12 | Stream B sample |
| a_avg | output | 12 | Stream A 32-sample average |
| a_vld | output | 1 | Stream A valid pulse after an accepted sample once the window is full |
| b_avg | output | 12 | Stream B 32-sample average |
| b_vld | output | 1 | Stream B valid pulse after an accepted sample once the window is full |

## Verification
The hardest state to reach is a full window whose oldest entry has the opposite extreme to the incoming value. This is where the 13-bit difference reaches about ±4095 while the sum sits at its limit. The stimulus gets there by filling a stream with 0x7FF, then switching it to 0x800 for a further 32 samples, and repeating this against an unsigned copy where 0xFFF gives way to 0x000. A long run with random gaps and independently random strobes on the two streams then checks that the window stays aligned with accepted samples, not with clock cycles.

// File: rtl/mavg_pkg.sv
// Shared definitions for the dual-stream boxcar averager.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mavg_pkg;

    // How a raw sample word is interpreted by every stream.
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } sample_mode_e;

    // Number of independent streams the top instantiates.
    localparam int unsigned MAVG_STREAMS = 2;

endpackage

// File: rtl/mavg_history.sv
// Delay line of past accepted samples for one stream.
// Shifts by one place per accepted sample; presents the sample that leaves
// the window on the next accept (the one accepted DEPTH accepts ago).
// Assumes: reset clears all entries to zero so fill-up reads zeros.
module mavg_history #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] oldest
);

    logic [DATA_W-1:0] tap_q [DEPTH];

    // Shift the delay line on each accepted sample; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) tap_q[i] <= '0;
        end else if (push) begin
            tap_q[0] <= din;
            for (int i = 1; i < int'(DEPTH); i++) tap_q[i] <= tap_q[i-1];
        end
    end

    assign oldest = tap_q[DEPTH-1];

    // R3: the history only moves when a sample is accepted.
    a_r3_history_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(oldest));

endmodule

// File: rtl/mavg_accum.sv
// Recursive running-sum for one stream: sum += extend(new) - extend(oldest).
// The average is the sum with WIN_LOG2 low bits dropped (floor division).
// Assumes: oldest is the sample that leaves the window on this accept.
module mavg_accum
    import mavg_pkg::*;
#(
    parameter int unsigned  DATA_W   = 12,
    parameter int unsigned  WIN_LOG2 = 5,
    parameter sample_mode_e MODE     = MODE_SIGNED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] newest,
    input  logic [DATA_W-1:0] oldest,
    output logic [DATA_W-1:0] avg
);

    localparam int unsigned DIFF_W = DATA_W + 1;
    localparam int unsigned ACC_W  = DATA_W + WIN_LOG2 + 1;
    localparam longint      WIN    = longint'(1) << WIN_LOG2;
    localparam longint      LIM_HI = (MODE == MODE_SIGNED)
                                     ? WIN * ((longint'(1) << (DATA_W-1)) - 1)
                                     : WIN * ((longint'(1) << DATA_W) - 1);
    localparam longint      LIM_LO = (MODE == MODE_SIGNED)
                                     ? -(WIN * (longint'(1) << (DATA_W-1)))
                                     : longint'(0);

    logic signed [DIFF_W-1:0] new_x;
    logic signed [DIFF_W-1:0] old_x;
    logic signed [DIFF_W-1:0] diff;
    logic signed [ACC_W-1:0]  diff_w;
    logic signed [ACC_W-1:0]  acc_q;

    // Widen samples by one bit according to the build-time mode.
    generate
        if (MODE == MODE_SIGNED) begin : g_sext
            assign new_x = {newest[DATA_W-1], newest};
            assign old_x = {oldest[DATA_W-1], oldest};
        end else begin : g_zext
            assign new_x = {1'b0, newest};
            assign old_x = {1'b0, oldest};
        end
    endgenerate

    // Difference between entering and leaving sample, sign-extended to sum width.
    always_comb begin
        diff   = new_x - old_x;
        diff_w = {{(ACC_W-DIFF_W){diff[DIFF_W-1]}}, diff};
    end

    // Feedback accumulator: one add per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (push) acc_q <= acc_q + diff_w;
    end

    assign avg = acc_q[DATA_W+WIN_LOG2-1:WIN_LOG2];

    // R4: the running sum stays inside the range of 32 legal samples.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(acc_q) >= LIM_LO) && (longint'(acc_q) <= LIM_HI));

    // R3: without an accepted sample the average holds.
    a_r3_avg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(avg));

endmodule

// File: rtl/mavg_fill.sv
// Fill tracker for one stream: counts accepted samples up to the window size
// and raises a one-cycle valid pulse after each accept once the window is full.
// Assumes: push is the same strobe the history and accumulator use.
module mavg_fill #(
    parameter int unsigned WIN_LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    output logic valid
);

    localparam int unsigned CNT_W   = WIN_LOG2 + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << WIN_LOG2;
    localparam logic [CNT_W-1:0] LAST_CNT = FULL_CNT - CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             valid_q;

    // Saturating count of accepted samples since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (push && cnt_q != FULL_CNT) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Valid pulse on the cycle after the 32nd and every later accept.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= push && (cnt_q >= LAST_CNT);
    end

    assign valid = valid_q;

    // R6: valid follows an accepted sample.
    a_r6_valid_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(push));

    // R6: valid only once the window has filled.
    a_r6_valid_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (cnt_q == FULL_CNT));

    // R6: the fill count saturates at the window size.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

endmodule

// File: rtl/mavg_lane.sv
// One complete averaging stream: history, recursive accumulator, fill tracker.
// Assumes: the strobe marks exactly the cycles with a valid sample.
module mavg_lane
    import mavg_pkg::*;
#(
    parameter int unsigned  DATA_W   = 12,
    parameter int unsigned  WIN_LOG2 = 5,
    parameter sample_mode_e MODE     = MODE_SIGNED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [DATA_W-1:0] smp,
    output logic [DATA_W-1:0] avg,
    output logic              vld
);

    localparam int unsigned DEPTH = 1 << WIN_LOG2;

    logic [DATA_W-1:0] leaving;

    mavg_history #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (stb),
        .din    (smp),
        .oldest (leaving)
    );

    mavg_accum #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2), .MODE(MODE)) i_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (stb),
        .newest (smp),
        .oldest (leaving),
        .avg    (avg)
    );

    mavg_fill #(.WIN_LOG2(WIN_LOG2)) i_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stb),
        .valid (vld)
    );

endmodule

// File: rtl/dual_boxcar_avg.sv
// Two independently strobed 2**WIN_LOG2-sample boxcar averagers sharing one
// interpretation mode. Each stream keeps its own history and running sum.
// Assumes: synchronous active-low reset, one clock domain.
module dual_boxcar_avg
    import mavg_pkg::*;
#(
    parameter int unsigned  DATA_W   = 12,
    parameter int unsigned  WIN_LOG2 = 5,
    parameter sample_mode_e MODE     = MODE_SIGNED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_stb,
    input  logic [DATA_W-1:0] a_smp,
    input  logic              b_stb,
    input  logic [DATA_W-1:0] b_smp,
    output logic [DATA_W-1:0] a_avg,
    output logic              a_vld,
    output logic [DATA_W-1:0] b_avg,
    output logic              b_vld
);

    logic              stb_v [MAVG_STREAMS];
    logic [DATA_W-1:0] smp_v [MAVG_STREAMS];
    logic [DATA_W-1:0] avg_v [MAVG_STREAMS];
    logic              vld_v [MAVG_STREAMS];

    // Map the named stream ports onto the lane vectors.
    always_comb begin
        stb_v[0] = a_stb;
        smp_v[0] = a_smp;
        stb_v[1] = b_stb;
        smp_v[1] = b_smp;
    end

    assign a_avg = avg_v[0];
    assign a_vld = vld_v[0];
    assign b_avg = avg_v[1];
    assign b_vld = vld_v[1];

    generate
        for (genvar g = 0; g < int'(MAVG_STREAMS); g++) begin : g_lane
            mavg_lane #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2), .MODE(MODE)) i_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .stb   (stb_v[g]),
                .smp   (smp_v[g]),
                .avg   (avg_v[g]),
                .vld   (vld_v[g])
            );

            // R7: a stream's average moves only on its own strobe.
            a_r7_lane_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                !stb_v[g] |=> $stable(avg_v[g]));
        end
    endgenerate

endmodule

// File: tb/test_dual_boxcar_avg.sv
module test_dual_boxcar_avg;
    import mavg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_stb = 1'b0, b_stb = 1'b0;
    logic [11:0] a_smp = '0, b_smp = '0;
    logic [11:0] a_avg, b_avg, ua_avg, ub_avg;
    logic        a_vld, b_vld, ua_vld, ub_vld;

    int n_chk = 0;
    int n_bad = 0;

    logic [11:0] hist [2][32];
    int          nacc [2];

    always #2 clk = ~clk;

    dual_boxcar_avg i_dual_boxcar_avg (
        .clk(clk), .rst_n(rst_n),
        .a_stb(a_stb), .a_smp(a_smp), .b_stb(b_stb), .b_smp(b_smp),
        .a_avg(a_avg), .a_vld(a_vld), .b_avg(b_avg), .b_vld(b_vld)
    );

    dual_boxcar_avg #(.MODE(MODE_UNSIGNED)) i_dual_boxcar_avg_uns (
        .clk(clk), .rst_n(rst_n),
        .a_stb(a_stb), .a_smp(a_smp), .b_stb(b_stb), .b_smp(b_smp),
        .a_avg(ua_avg), .a_vld(ua_vld), .b_avg(ub_avg), .b_vld(ub_vld)
    );

    task automatic chk(string tag, string what, logic [11:0] act, logic [11:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic void model_clear();
        for (int c = 0; c < 2; c++) begin
            nacc[c] = 0;
            for (int i = 0; i < 32; i++) hist[c][i] = '0;
        end
    endfunction

    function automatic void model_push(int c, logic [11:0] d);
        for (int i = 31; i > 0; i--) hist[c][i] = hist[c][i-1];
        hist[c][0] = d;
        nacc[c]++;
    endfunction

    function automatic logic [11:0] model_avg(int c, bit sgn);
        int s = 0;
        for (int i = 0; i < 32; i++)
            s += sgn ? int'($signed(hist[c][i])) : int'(hist[c][i]);
        return 12'(s >>> 5);
    endfunction

    // One clock: drive at negedge, compare every output after the rising edge.
    task automatic step(bit e0, bit e1, logic [11:0] d0, logic [11:0] d1, string tag);
        @(negedge clk);
        a_stb = e0; b_stb = e1; a_smp = d0; b_smp = d1;
        @(posedge clk);
        #1;
        if (e0) model_push(0, d0);
        if (e1) model_push(1, d1);
        chk(tag, "a_avg signed",   a_avg,  model_avg(0, 1'b1));
        chk(tag, "b_avg signed",   b_avg,  model_avg(1, 1'b1));
        chk(tag, "a_avg unsigned", ua_avg, model_avg(0, 1'b0));
        chk(tag, "b_avg unsigned", ub_avg, model_avg(1, 1'b0));
        chk({tag, "/R6"}, "a_vld", 12'(a_vld),  12'(e0 && nacc[0] >= 32));
        chk({tag, "/R6"}, "b_vld", 12'(b_vld),  12'(e1 && nacc[1] >= 32));
        chk({tag, "/R6"}, "ua_vld", 12'(ua_vld), 12'(e0 && nacc[0] >= 32));
        chk({tag, "/R6"}, "ub_vld", 12'(ub_vld), 12'(e1 && nacc[1] >= 32));
    endtask

    // R1: reset clears both streams in both instances.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; a_stb = 1'b1; b_stb = 1'b1; a_smp = 12'h123; b_smp = 12'h456;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R1", "a_avg", a_avg, '0);
        chk("R1", "b_avg", b_avg, '0);
        chk("R1", "ua_avg", ua_avg, '0);
        chk("R1", "a_vld", 12'(a_vld), '0);
        chk("R1", "b_vld", 12'(b_vld), '0);
        @(negedge clk);
        rst_n = 1'b1; a_stb = 1'b0; b_stb = 1'b0;
        model_clear();
    endtask

    // R5: constant input with gaps ramps up from zero during fill.
    task automatic t_fill_ramp();
        for (int k = 0; k < 40; k++) begin
            step(1'b1, 1'b0, 12'd100, 12'd0, "R5");
            if (k % 3 == 0) step(1'b0, 1'b0, 12'd7, 12'd9, "R3");
        end
    endtask

    // R2: step change from one level to another on stream B.
    task automatic t_step();
        for (int k = 0; k < 36; k++) step(1'b0, 1'b1, 12'd40, 12'd0, "R2");
        for (int k = 0; k < 40; k++) step(1'b0, 1'b1, 12'hFD0, 12'd0, "R2");
    endtask

    // R4/R8: extreme values and full-scale swings in both modes.
    task automatic t_extremes();
        for (int k = 0; k < 34; k++) step(1'b1, 1'b1, 12'h7FF, 12'hFFF, "R4");
        chk("R4", "a_avg max", a_avg, 12'h7FF);
        chk("R8", "ub_avg max", ub_avg, 12'hFFF);
        for (int k = 0; k < 34; k++) step(1'b1, 1'b1, 12'h800, 12'h000, "R4");
        chk("R4", "a_avg min", a_avg, 12'h800);
        chk("R8", "ub_avg zero", ub_avg, 12'h000);
        for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 12'h800, 12'h801, "R8");
    endtask

    // R7: only one stream strobes; the other must not move.
    task automatic t_isolation();
        for (int k = 0; k < 40; k++) step(1'b0, 1'b1, 12'hABC, 12'(k * 37), "R7");
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 12'(k * 101), 12'h111, "R7");
    endtask

    // R2/R3: random samples, random independent strobes and gaps.
    task automatic t_random();
        for (int k = 0; k < 600; k++) begin
            logic [11:0] d0 = 12'($urandom);
            logic [11:0] d1 = 12'($urandom);
            if ((k % 50) == 5)  d0 = 12'h7FF;
            if ((k % 50) == 30) d1 = 12'h800;
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0), d0, d1, "R2");
            if ($urandom_range(0, 3) == 0) step(1'b0, 1'b0, d1, d0, "R3");
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        t_reset();
        t_fill_ramp();
        t_step();
        t_extremes();
        t_isolation();
        t_reset();
        t_random();
        t_reset();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule